// File: doc/BRIEF.md
# VGA Planar Pixel Data Path

This block is the pixel arithmetic that sits between an 8-bit host data byte and a 32-bit frame-buffer word. The word holds four bit planes of eight bits each. Plane p occupies word bits [8p+7:8p]. Address generation and plane write enables belong to neighbouring logic. This block only shapes the data.

On a host write, the byte can be rotated, replaced per plane by set/reset bits, or expanded from single host bits. The result is merged bit by bit with a 32-bit display latch under a bit mask. The word is presented to memory one cycle later. On a frame-buffer read, the returned word always reloads the latch. The host then receives either one selected plane or a colour-compare byte built across the planes. A small control port holds the write settings, the read settings and the latch itself.

Top module: `vga_plane_alu`

Control addresses on `ctl_addr_i`:

| Address | Register |
|---|---|
| 0 | Write settings |
| 1 | Read settings |
| 2 | Latch |
| 3 | Reads as zero |

Write settings fields:

| Bits | Field |
|---|---|
| [2:0] | Rotate amount |
| [3] | Expand flag |
| [4] | Mask-by-data flag |
| [11:8] | Per-plane set/reset enables |
| [15:12] | Per-plane set/reset values |
| [23:16] | Bit mask |

Read settings fields:

| Bits | Field |
|---|---|
| [1:0] | Plane select |
| [2] | Compare mode |
| [7:4] | Compare plane mask |
| [11:8] | Colour value |

## Requirements
- R1: After reset, every output is 0, and the write settings, read settings and latch all read back as 0.
- R2: A control write to address 0 or 1 stores only the defined fields. Address 0 reads back as data AND 0x00FFFF1F. Address 1 reads back as data AND 0x00000FF7. Address 3 reads 0. `ctl_rdata_o` follows `ctl_addr_i` in the same cycle.
- R3: Each cycle with `mem_rvalid_i` high loads `mem_rdata_i` into the latch, which is visible from the next cycle. A control write to address 2 loads the latch in the same way. When both happen in the same cycle, the memory data wins. Otherwise the latch holds.
- R4: `mem_we_o` is high exactly in the cycle after `host_we_i`, with `mem_wdata_o` built from the host byte, the settings and the latch as they were in the `host_we_i` cycle. `mem_wdata_o` holds its value between writes.
- R5: In the default mode (both flags 0), the host byte is rotated right by the rotate amount before use.
- R6: In the default mode, a plane whose set/reset enable is 1 takes eight copies of its set/reset value instead of the rotated byte.
- R7: Each plane byte is out = (src AND m) OR (latch plane AND NOT m). A mask bit of 0 keeps the latch bit.
- R8: With only the expand flag set, plane p takes eight copies of host bit p. Rotation and set/reset enables are ignored, and the mask is the bit mask.
- R9: With the mask-by-data flag set (whatever the expand flag), plane p takes eight copies of its set/reset value, and m is the bit mask AND the rotated host byte.
- R10: `mem_re_o` equals `host_re_i` in the same cycle. One cycle after `mem_rvalid_i`, `host_rvalid_o` is high. When compare mode is 0, `host_rdata_o` is then plane "plane select" of the returned word.
- R11: When compare mode is 1, bit i of `host_rdata_o` is 1 exactly when, for every plane p enabled in the compare mask, bit i of plane p equals colour bit p. An all-zero compare mask gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe |
| host_wdata_i | input | 8 | Host write byte |
| host_rvalid_o | output | 1 | Host read byte valid |
| host_rdata_o | output | 8 | Host read byte |
| mem_re_o | output | 1 | Frame-buffer read request |
| mem_we_o | output | 1 | Frame-buffer write request |
| mem_wdata_o | output | 32 | Frame-buffer write word, four planes |
| mem_rvalid_i | input | 1 | Frame-buffer read data valid |
| mem_rdata_i | input | 32 | Frame-buffer read word |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_addr_i | input | 2 | Control register select |
| ctl_wdata_i | input | 32 | Control write data |
| ctl_rdata_o | output | 32 | Control read data |

## Verification
Memory write words and host read bytes are due one clock after the strobe that causes them. The control read data and `mem_re_o` are due in the same cycle. A latch update first shows on the following cycle. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares every output at the next falling edge, so each result is sampled in exactly the cycle its register chain predicts. Directed cases with hand-computed words cover each mode, the mode priority and the latch collision. A randomized stretch then mixes modes, reads and latch writes.

// File: rtl/vga_plane_pkg.sv
package vga_plane_pkg;

  typedef enum logic [1:0] {
    WMODE_0 = 2'd0,
    WMODE_2 = 2'd1,
    WMODE_3 = 2'd2
  } wmode_e;

  localparam logic [1:0] CSEL_WCFG  = 2'd0;
  localparam logic [1:0] CSEL_RCFG  = 2'd1;
  localparam logic [1:0] CSEL_LATCH = 2'd2;

  // mask-by-data flag outranks expand flag
  function automatic wmode_e pick_wmode(input logic f2, input logic f3);
    if (f3) return WMODE_3;
    if (f2) return WMODE_2;
    return WMODE_0;
  endfunction

endpackage

// File: rtl/vga_ctl_regs.sv
module vga_ctl_regs
  import vga_plane_pkg::*;
#(
  parameter int NP = 4,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic [1:0]    ctl_addr_i,
  input  logic [NP*PW-1:0] ctl_wdata_i,
  output logic [NP*PW-1:0] ctl_rdata_o,
  input  logic          mem_rvalid_i,
  input  logic [NP*PW-1:0] mem_rdata_i,
  output logic [$clog2(PW)-1:0] rot_o,
  output logic          f2_o,
  output logic          f3_o,
  output logic [NP-1:0] sr_en_o,
  output logic [NP-1:0] sr_val_o,
  output logic [PW-1:0] mask_o,
  output logic [$clog2(NP)-1:0] map_o,
  output logic          cmp_mode_o,
  output logic [NP-1:0] cmp_mask_o,
  output logic [NP-1:0] colour_o,
  output logic [NP*PW-1:0] latch_o
);
  localparam int W      = NP * PW;
  localparam int RW     = $clog2(PW);
  localparam int SW     = $clog2(NP);
  localparam int F2_BIT = RW;
  localparam int F3_BIT = RW + 1;
  localparam int SRE_LO = 8;
  localparam int SRV_LO = SRE_LO + NP;
  localparam int MSK_LO = 16;
  localparam int RMD_BIT = SW;
  localparam int CMK_LO = 4;
  localparam int CLR_LO = CMK_LO + NP;

  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] WCFG_MASK = ((ONE << (RW + 2)) - ONE)
                                     | (((ONE << (2 * NP)) - ONE) << SRE_LO)
                                     | (((ONE << PW) - ONE) << MSK_LO);
  localparam logic [W-1:0] RCFG_MASK = ((ONE << (SW + 1)) - ONE)
                                     | (((ONE << (2 * NP)) - ONE) << CMK_LO);

  logic [W-1:0] wcfg_q, rcfg_q, latch_q;
  logic         latch_ctl_wr;

  assign latch_ctl_wr = ctl_we_i && (ctl_addr_i == CSEL_LATCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcfg_q  <= '0;
      rcfg_q  <= '0;
      latch_q <= '0;
    end else begin
      if (ctl_we_i && ctl_addr_i == CSEL_WCFG) wcfg_q <= ctl_wdata_i & WCFG_MASK;
      if (ctl_we_i && ctl_addr_i == CSEL_RCFG) rcfg_q <= ctl_wdata_i & RCFG_MASK;
      if (mem_rvalid_i)      latch_q <= mem_rdata_i;
      else if (latch_ctl_wr) latch_q <= ctl_wdata_i;
    end
  end

  always_comb begin
    unique case (ctl_addr_i)
      CSEL_WCFG:  ctl_rdata_o = wcfg_q;
      CSEL_RCFG:  ctl_rdata_o = rcfg_q;
      CSEL_LATCH: ctl_rdata_o = latch_q;
      default:    ctl_rdata_o = '0;
    endcase
  end

  assign rot_o      = wcfg_q[RW-1:0];
  assign f2_o       = wcfg_q[F2_BIT];
  assign f3_o       = wcfg_q[F3_BIT];
  assign sr_en_o    = wcfg_q[SRE_LO +: NP];
  assign sr_val_o   = wcfg_q[SRV_LO +: NP];
  assign mask_o     = wcfg_q[MSK_LO +: PW];
  assign map_o      = rcfg_q[SW-1:0];
  assign cmp_mode_o = rcfg_q[RMD_BIT];
  assign cmp_mask_o = rcfg_q[CMK_LO +: NP];
  assign colour_o   = rcfg_q[CLR_LO +: NP];
  assign latch_o    = latch_q;

  // R3
  latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |=> latch_q == $past(mem_rdata_i));
  // R3
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_rvalid_i && !latch_ctl_wr) |=> $stable(latch_q));

endmodule

// File: rtl/vga_write_path.sv
module vga_write_path
  import vga_plane_pkg::*;
#(
  parameter int NP = 4,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] data_i,
  input  logic [$clog2(PW)-1:0] rot_i,
  input  logic          f2_i,
  input  logic          f3_i,
  input  logic [NP-1:0] sr_en_i,
  input  logic [NP-1:0] sr_val_i,
  input  logic [PW-1:0] mask_i,
  input  logic [NP*PW-1:0] latch_i,
  output logic          we_o,
  output logic [NP*PW-1:0] wdata_o
);
  localparam int W = NP * PW;

  wmode_e          mode;
  logic [2*PW-1:0] dbl;
  logic [PW-1:0]   rotated;
  logic [W-1:0]    word;

  assign mode    = pick_wmode(f2_i, f3_i);
  assign dbl     = {data_i, data_i} >> rot_i;
  assign rotated = dbl[PW-1:0];

  for (genvar p = 0; p < NP; p++) begin : g_plane
    logic [PW-1:0] src, msk;
    always_comb begin
      unique case (mode)
        WMODE_2: begin
          src = {PW{data_i[p]}};
          msk = mask_i;
        end
        WMODE_3: begin
          src = {PW{sr_val_i[p]}};
          msk = mask_i & rotated;
        end
        default: begin
          src = sr_en_i[p] ? {PW{sr_val_i[p]}} : rotated;
          msk = mask_i;
        end
      endcase
    end
    assign word[p*PW +: PW] = (src & msk) | (latch_i[p*PW +: PW] & ~msk);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      wdata_o <= '0;
    end else begin
      we_o <= we_i;
      if (we_i) wdata_o <= word;
    end
  end

  // R7
  mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mode != WMODE_3 && mask_i == '0) |=> wdata_o == $past(latch_i));
  // R4
  wdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(wdata_o));

endmodule

// File: rtl/vga_read_path.sv
module vga_read_path #(
  parameter int NP = 4,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rvalid_i,
  input  logic [NP*PW-1:0] rdata_i,
  input  logic [$clog2(NP)-1:0] map_i,
  input  logic          cmp_mode_i,
  input  logic [NP-1:0] cmp_mask_i,
  input  logic [NP-1:0] colour_i,
  output logic          rvalid_o,
  output logic [PW-1:0] rdata_o
);
  logic [NP-1:0] col_bits [PW];
  logic [PW-1:0] cmp_byte, sel_byte, result;

  for (genvar i = 0; i < PW; i++) begin : g_bit
    for (genvar p = 0; p < NP; p++) begin : g_pl
      assign col_bits[i][p] = rdata_i[p*PW + i];
    end
    assign cmp_byte[i] = &(~cmp_mask_i | ~(col_bits[i] ^ colour_i));
  end

  assign sel_byte = rdata_i[int'(map_i)*PW +: PW];
  assign result   = cmp_mode_i ? cmp_byte : sel_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rvalid_i;
      if (rvalid_i) rdata_o <= result;
    end
  end

  // R10
  rvalid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i |=> rvalid_o);
  // R11
  cmp_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_i && cmp_mode_i && cmp_mask_i == '0) |=> rdata_o == '1);

endmodule

// File: rtl/vga_plane_alu.sv
module vga_plane_alu
  import vga_plane_pkg::*;
#(
  parameter int NUM_PLANES = 4,
  parameter int PLANE_W    = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          host_we_i,
  input  logic                          host_re_i,
  input  logic [PLANE_W-1:0]            host_wdata_i,
  output logic                          host_rvalid_o,
  output logic [PLANE_W-1:0]            host_rdata_o,
  output logic                          mem_re_o,
  output logic                          mem_we_o,
  output logic [NUM_PLANES*PLANE_W-1:0] mem_wdata_o,
  input  logic                          mem_rvalid_i,
  input  logic [NUM_PLANES*PLANE_W-1:0] mem_rdata_i,
  input  logic                          ctl_we_i,
  input  logic [1:0]                    ctl_addr_i,
  input  logic [NUM_PLANES*PLANE_W-1:0] ctl_wdata_i,
  output logic [NUM_PLANES*PLANE_W-1:0] ctl_rdata_o
);
  localparam int W  = NUM_PLANES * PLANE_W;
  localparam int RW = $clog2(PLANE_W);
  localparam int SW = $clog2(NUM_PLANES);

  logic [RW-1:0]         rot;
  logic                  f2, f3, cmp_mode;
  logic [NUM_PLANES-1:0] sr_en, sr_val, cmp_mask, colour;
  logic [PLANE_W-1:0]    bit_mask;
  logic [SW-1:0]         map_sel;
  logic [W-1:0]          latch;

  assign mem_re_o = host_re_i;

  vga_ctl_regs #(.NP(NUM_PLANES), .PW(PLANE_W)) u_regs (
    .clk_i, .rst_ni,
    .ctl_we_i, .ctl_addr_i, .ctl_wdata_i, .ctl_rdata_o,
    .mem_rvalid_i, .mem_rdata_i,
    .rot_o(rot), .f2_o(f2), .f3_o(f3),
    .sr_en_o(sr_en), .sr_val_o(sr_val), .mask_o(bit_mask),
    .map_o(map_sel), .cmp_mode_o(cmp_mode), .cmp_mask_o(cmp_mask),
    .colour_o(colour), .latch_o(latch)
  );

  vga_write_path #(.NP(NUM_PLANES), .PW(PLANE_W)) u_wr (
    .clk_i, .rst_ni,
    .we_i(host_we_i), .data_i(host_wdata_i), .rot_i(rot),
    .f2_i(f2), .f3_i(f3), .sr_en_i(sr_en), .sr_val_i(sr_val),
    .mask_i(bit_mask), .latch_i(latch),
    .we_o(mem_we_o), .wdata_o(mem_wdata_o)
  );

  vga_read_path #(.NP(NUM_PLANES), .PW(PLANE_W)) u_rd (
    .clk_i, .rst_ni,
    .rvalid_i(mem_rvalid_i), .rdata_i(mem_rdata_i),
    .map_i(map_sel), .cmp_mode_i(cmp_mode), .cmp_mask_i(cmp_mask),
    .colour_i(colour),
    .rvalid_o(host_rvalid_o), .rdata_o(host_rdata_o)
  );

  // R4
  wr_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i |=> mem_we_o);
  // R4
  wr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_we_i |=> !mem_we_o);

endmodule

// File: tb/vga_plane_alu_bench.sv
`timescale 1ns/1ps
module vga_plane_alu_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_we = 1'b0, host_re = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic        host_rvalid, mem_re, mem_we;
  logic [7:0]  host_rdata;
  logic [31:0] mem_wdata, ctl_rdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_addr = '0;
  logic [31:0] ctl_wdata = '0;

  always #2 clk = ~clk;

  vga_plane_alu u_vga_plane_alu (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_we_i(host_we), .host_re_i(host_re), .host_wdata_i(host_wdata),
    .host_rvalid_o(host_rvalid), .host_rdata_o(host_rdata),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .ctl_we_i(ctl_we), .ctl_addr_i(ctl_addr), .ctl_wdata_i(ctl_wdata),
    .ctl_rdata_o(ctl_rdata)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag = "R1";

  // reference state
  logic [31:0] m_wcfg = '0, m_rcfg = '0, m_latch = '0, e_wdata = '0;
  logic        e_we = 0, e_rvalid = 0;
  logic [7:0]  e_rdata = '0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f_write(logic [7:0] h, logic [31:0] wc, logic [31:0] lat);
    int r = int'(wc[2:0]);
    int hv = int'(h);
    int rot = ((hv >> r) | (hv << (8 - r))) & 255;
    logic [31:0] res = '0;
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 8; i++) begin
        bit s, m;
        bit rb = rot[i];
        bit mb = wc[16 + i];
        if (wc[4]) begin s = wc[12 + p]; m = mb & rb; end
        else if (wc[3]) begin s = h[p]; m = mb; end
        else begin s = wc[8 + p] ? wc[12 + p] : rb; m = mb; end
        res[8*p + i] = m ? s : lat[8*p + i];
      end
    end
    return res;
  endfunction

  function automatic logic [7:0] f_read(logic [31:0] d, logic [31:0] rc);
    logic [7:0] res;
    if (!rc[2]) return d[8*int'(rc[1:0]) +: 8];
    for (int i = 0; i < 8; i++) begin
      res[i] = 1'b1;
      for (int p = 0; p < 4; p++)
        if (rc[4 + p] && d[8*p + i] != rc[8 + p]) res[i] = 1'b0;
    end
    return res;
  endfunction

  function automatic logic [31:0] f_ctl(logic [1:0] a);
    case (a)
      2'd0: return m_wcfg;
      2'd1: return m_rcfg;
      2'd2: return m_latch;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_edge();
    e_we = host_we;
    if (host_we) e_wdata = f_write(host_wdata, m_wcfg, m_latch);
    e_rvalid = mem_rvalid;
    if (mem_rvalid) e_rdata = f_read(mem_rdata, m_rcfg);
    if (ctl_we && ctl_addr == 2'd0) m_wcfg = ctl_wdata & 32'h00FFFF1F;
    if (ctl_we && ctl_addr == 2'd1) m_rcfg = ctl_wdata & 32'h00000FF7;
    if (mem_rvalid) m_latch = mem_rdata;
    else if (ctl_we && ctl_addr == 2'd2) m_latch = ctl_wdata;
  endtask

  task automatic compare_all();
    chk(cur_tag, "mem_we", mem_we, e_we);
    chk(cur_tag, "mem_wdata", mem_wdata, e_wdata);
    chk(cur_tag, "host_rvalid", host_rvalid, e_rvalid);
    chk(cur_tag, "host_rdata", host_rdata, e_rdata);
    chk(cur_tag, "ctl_rdata", ctl_rdata, f_ctl(ctl_addr));
    chk(cur_tag, "mem_re", mem_re, host_re);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic set_ctl(logic [1:0] a, logic [31:0] d);
    ctl_we = 1; ctl_addr = a; ctl_wdata = d;
    tick();
    ctl_we = 0;
  endtask

  task automatic host_write(logic [7:0] d);
    host_we = 1; host_wdata = d;
    tick();
    host_we = 0;
  endtask

  task automatic mem_return(logic [31:0] d);
    mem_rvalid = 1; mem_rdata = d;
    tick();
    mem_rvalid = 0;
  endtask

  task automatic peek_ctl(string tag, logic [1:0] a, logic [31:0] exp);
    ctl_addr = a;
    #1 chk(tag, "ctl readback", ctl_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    cur_tag = "R1";
    chk("R1", "mem_we", mem_we, 0);
    chk("R1", "mem_wdata", mem_wdata, 0);
    chk("R1", "host_rvalid", host_rvalid, 0);
    chk("R1", "host_rdata", host_rdata, 0);
    peek_ctl("R1", 2'd0, 0);
    peek_ctl("R1", 2'd1, 0);
    peek_ctl("R1", 2'd2, 0);
    tick();

    // R2 field masking
    cur_tag = "R2";
    set_ctl(2'd0, 32'hFFFF_FFFF);
    peek_ctl("R2", 2'd0, 32'h00FF_FF1F);
    set_ctl(2'd1, 32'hFFFF_FFFF);
    peek_ctl("R2", 2'd1, 32'h0000_0FF7);
    set_ctl(2'd3, 32'hFFFF_FFFF);
    peek_ctl("R2", 2'd3, 32'h0);
    set_ctl(2'd1, 32'h0);

    // R3 latch loading
    cur_tag = "R3";
    mem_return(32'hA5C3_3C5A);
    peek_ctl("R3", 2'd2, 32'hA5C3_3C5A);
    set_ctl(2'd2, 32'h1122_3344);
    peek_ctl("R3", 2'd2, 32'h1122_3344);
    mem_rvalid = 1; mem_rdata = 32'hDEAD_BEEF;
    ctl_we = 1; ctl_addr = 2'd2; ctl_wdata = 32'h0;
    tick();
    mem_rvalid = 0; ctl_we = 0;
    peek_ctl("R3", 2'd2, 32'hDEAD_BEEF);
    set_ctl(2'd2, 32'h0);

    // R5 rotate, R4 timing
    cur_tag = "R5";
    set_ctl(2'd0, 32'h00FF_0001);
    host_write(8'h01);
    chk("R4", "mem_we after strobe", mem_we, 1);
    chk("R5", "rotated word", mem_wdata, 32'h8080_8080);
    tick();
    chk("R4", "mem_we idle", mem_we, 0);
    chk("R4", "wdata hold", mem_wdata, 32'h8080_8080);

    // R6 set/reset
    cur_tag = "R6";
    set_ctl(2'd0, 32'h00FF_1300);
    host_write(8'h5A);
    chk("R6", "set/reset word", mem_wdata, 32'h5A5A_00FF);

    // R7 bit mask vs latch
    cur_tag = "R7";
    set_ctl(2'd2, 32'h1234_5678);
    set_ctl(2'd0, 32'h000F_0000);
    host_write(8'hFF);
    chk("R7", "masked word", mem_wdata, 32'h1F3F_5F7F);
    set_ctl(2'd2, 32'h0);

    // R8 expand mode
    cur_tag = "R8";
    set_ctl(2'd0, 32'h00FF_0F0B);
    host_write(8'h05);
    chk("R8", "expand word", mem_wdata, 32'h00FF_00FF);

    // R9 mask-by-data mode and priority
    cur_tag = "R9";
    set_ctl(2'd0, 32'h000F_5018);
    host_write(8'hFF);
    chk("R9", "priority word", mem_wdata, 32'h000F_000F);
    set_ctl(2'd0, 32'h00FF_5014);
    host_write(8'h0F);
    chk("R9", "rotated mask word", mem_wdata, 32'h00F0_00F0);

    // R10 plane select
    cur_tag = "R10";
    set_ctl(2'd1, 32'h0000_0002);
    host_re = 1;
    #1 chk("R10", "mem_re same cycle", mem_re, 1);
    tick();
    host_re = 0;
    mem_return(32'h4433_2211);
    chk("R10", "rvalid", host_rvalid, 1);
    chk("R10", "plane byte", host_rdata, 8'h33);
    tick();
    chk("R10", "rvalid drop", host_rvalid, 0);

    // R11 colour compare
    cur_tag = "R11";
    set_ctl(2'd1, 32'h0000_0AF4);
    mem_return(32'hFF00_FF00);
    chk("R11", "all match", host_rdata, 8'hFF);
    mem_return(32'hFF00_FF01);
    chk("R11", "bit0 mismatch", host_rdata, 8'hFE);
    set_ctl(2'd1, 32'h0000_0A04);
    mem_return(32'h1234_5678);
    chk("R11", "empty mask", host_rdata, 8'hFF);

    // mixed traffic against the model
    cur_tag = "R4";
    for (int n = 0; n < 3000; n++) begin
      host_we    = ($urandom % 3) == 0;
      host_wdata = 8'($urandom);
      host_re    = ($urandom % 4) == 0;
      mem_rvalid = ($urandom % 3) == 0;
      mem_rdata  = $urandom;
      ctl_we     = ($urandom % 5) == 0;
      ctl_addr   = 2'($urandom);
      ctl_wdata  = $urandom;
      tick();
    end
    host_we = 0; host_re = 0; mem_rvalid = 0; ctl_we = 0;
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule